// File: doc/BRIEF.md
# SDRAM Bank Activate Timing Guard

This block sits beside the command path of a four-bank synchronous DRAM and watches every command that goes out. For each bank it keeps an open/closed flag and a count of the cycles since that bank was last opened. From this state it drives, for every bank, permission flags that say whether an open, a column access or a close is allowed in the current cycle. A controller can use these flags to hold back a command, and a test environment can use them to grade one.

When a command breaks a timing or state rule, the block raises a violation flag. The flag stays set until reset. A code beside it names the first rule that was broken. There are four spacing limits: open-to-column delay, same-bank open-to-open period, cross-bank open-to-open spacing, and the longest time a bank may stay open. Each is a cycle-count parameter. A power-down request is classified as a true power-down or, if a burst is running, as a clock suspend.

The command input is a valid-qualified stream with no ready signal. The block is an observer and never applies back-pressure: it takes one command in every cycle where `cmd_valid` is high, and ignores the other input fields in every cycle where it is low. All status outputs are plain level signals.

Top module: `sdram_act_guard`

## Requirements
- R1: Command codes on `cmd_op` are 0 idle, 1 open (activate), 2 read, 3 write, 4 close one bank, 5 close all banks, 6 power-down. `cmd_bank` selects one of four banks. When `cmd_valid` is low, the command has no effect. After reset every bank is closed, `act_ok` is 4'hF, `rw_ok` and `pre_ok` are 0, and the violation flag and code are 0.
- R2: `rw_ok[b]` is 1 only when bank b is open and at least T_RCD cycles have passed since its open. A read or write issued earlier than that raises code 5.
- R3: An open command to a bank that is already open raises code 1.
- R4: An open command to a closed bank less than T_RC cycles after that bank's previous open raises code 2.
- R5: An open command to a bank other than the most recently opened one, less than T_RRD cycles after that open, raises code 3.
- R6: A read or write to a closed bank raises code 4.
- R7: A bank still open T_RAS_MAX+1 cycles after its open raises code 6. A close issued T_RAS_MAX cycles after the open avoids it.
- R8: A close-one-bank command closes only the addressed bank. A close-all command closes every bank in the same cycle. `pre_ok[b]` shows that bank b is open.
- R9: The violation flag is registered and appears one cycle after the offending command. It then stays set until reset, and the code keeps the first violation. When several rules fail in one cycle, the lowest code wins.
- R10: A valid power-down command drives `pd_suspend` while `in_burst` is 1, and drives `pd_enter` otherwise. The two are never high together.
- R11: `act_ok[b]` is 1 exactly when an open to bank b in this cycle would raise no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Target bank |
| in_burst | input | 1 | A data burst is in progress |
| act_ok | output | 4 | Per-bank: open allowed now |
| rw_ok | output | 4 | Per-bank: read/write allowed now |
| pre_ok | output | 4 | Per-bank: bank open, close has effect |
| pd_enter | output | 1 | Power-down command accepted as power-down |
| pd_suspend | output | 1 | Power-down command turned into clock suspend |
| violation | output | 1 | Sticky rule-violation flag |
| viol_code | output | 3 | Code of the first violation |

## Verification
The bench sweeps the gap between an open and the next command across each limit, one cycle below and one cycle above. An off-by-one counter shows up as a violation at the legal gap, or as a miss at the illegal one. It checks that cross-bank spacing is separate from same-bank spacing, and that the tRAS bound trips on exactly the first cycle past the limit. A design that let a later violation overwrite the code is caught by chaining two faults. A design that let the close-all command leave a bank open is caught by reading `pre_ok` right after it.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_OPEN = 3'd1,
    OP_READ = 3'd2,
    OP_WRITE = 3'd3,
    OP_CLOSE = 3'd4,
    OP_CLOSE_ALL = 3'd5,
    OP_PDOWN = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    V_NONE = 3'd0,
    V_OPEN_BUSY = 3'd1,
    V_RC = 3'd2,
    V_RRD = 3'd3,
    V_RW_CLOSED = 3'd4,
    V_RCD = 3'd5,
    V_RAS = 3'd6
  } viol_e;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int T_RCD = 3,
  parameter int T_RC = 9,
  parameter int T_RAS_MAX = 30,
  parameter int CW = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_hit,
  input  logic close_hit,
  output logic is_open,
  output logic rc_met,
  output logic rw_ok,
  output logic ras_over
);
  localparam int SAT = (T_RC > T_RAS_MAX + 1) ? T_RC : T_RAS_MAX + 1;
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      age <= SAT_V;
    end else if (open_hit) begin
      is_open <= 1'b1;
      age <= CW'(1);
    end else begin
      if (close_hit) is_open <= 1'b0;
      if (age != SAT_V) age <= age + CW'(1);
    end
  end

  assign rc_met = (age >= CW'(T_RC));
  assign rw_ok = is_open && (age >= CW'(T_RCD));
  assign ras_over = is_open && (age > CW'(T_RAS_MAX));

  AST_OPEN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> (is_open && age == CW'(1) && !(T_RC > 1 && rc_met))); // R4
  AST_CLOSE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (close_hit && !open_hit) |=> !is_open); // R8
  AST_RCD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RCD > 1 && $rose(is_open)) |-> !rw_ok); // R2
endmodule

// File: rtl/open_spacing.sv
module open_spacing #(
  parameter int T_RRD = 2,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_fire,
  input  logic [BW-1:0] open_bank,
  output logic          rrd_met,
  output logic [BW-1:0] last_bank
);
  localparam int RW = $clog2(T_RRD + 1) < 1 ? 1 : $clog2(T_RRD + 1);
  localparam logic [RW-1:0] LIM = RW'(T_RRD);

  logic [RW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= LIM;
      last_bank <= '0;
    end else if (open_fire) begin
      since <= RW'(1);
      last_bank <= open_bank;
    end else if (since != LIM) begin
      since <= since + RW'(1);
    end
  end

  assign rrd_met = (since >= LIM);

  AST_RRD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD > 1 && open_fire) |=> !rrd_met); // R5
  AST_LAST_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    open_fire |=> last_bank == $past(open_bank)); // R5
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] evt_code,
  output logic       flag,
  output logic [2:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      code <= 3'd0;
    end else if (!flag && evt_code != 3'd0) begin
      flag <= 1'b1;
      code <= evt_code;
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> (flag && $stable(code))); // R9
  AST_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> code != 3'd0); // R9
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sdram_guard_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int T_RCD = 3,
  parameter int T_RC = 9,
  parameter int T_RRD = 2,
  parameter int T_RAS_MAX = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [BANK_BITS-1:0]      cmd_bank,
  input  logic                      in_burst,
  output logic [(1<<BANK_BITS)-1:0] act_ok,
  output logic [(1<<BANK_BITS)-1:0] rw_ok,
  output logic [(1<<BANK_BITS)-1:0] pre_ok,
  output logic                      pd_enter,
  output logic                      pd_suspend,
  output logic                      violation,
  output logic [2:0]                viol_code
);
  localparam int NB = 1 << BANK_BITS;
  localparam int SAT = (T_RC > T_RAS_MAX + 1) ? T_RC : T_RAS_MAX + 1;
  localparam int CW = $clog2(SAT + 1);

  op_e op;
  logic is_open_c, is_read_c, is_write_c, is_close_c, is_close_all_c, is_pd_c, is_rw_c;
  logic [NB-1:0] open_hit, close_hit, bank_open, rc_met, ras_over;
  logic rrd_met;
  logic [BANK_BITS-1:0] last_bank;
  viol_e evt;

  assign op = op_e'(cmd_op);
  assign is_open_c = cmd_valid && (op == OP_OPEN);
  assign is_read_c = cmd_valid && (op == OP_READ);
  assign is_write_c = cmd_valid && (op == OP_WRITE);
  assign is_close_c = cmd_valid && (op == OP_CLOSE);
  assign is_close_all_c = cmd_valid && (op == OP_CLOSE_ALL);
  assign is_pd_c = cmd_valid && (op == OP_PDOWN);
  assign is_rw_c = is_read_c || is_write_c;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign open_hit[b] = is_open_c && (cmd_bank == BANK_BITS'(b));
    assign close_hit[b] = is_close_all_c || (is_close_c && (cmd_bank == BANK_BITS'(b)));

    bank_tracker #(
      .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS_MAX(T_RAS_MAX), .CW(CW)
    ) i_bank (
      .clk(clk), .rst_n(rst_n),
      .open_hit(open_hit[b]), .close_hit(close_hit[b]),
      .is_open(bank_open[b]), .rc_met(rc_met[b]),
      .rw_ok(rw_ok[b]), .ras_over(ras_over[b])
    );

    assign act_ok[b] = !bank_open[b] && rc_met[b] &&
                       (rrd_met || last_bank == BANK_BITS'(b));
    assign pre_ok[b] = bank_open[b];
  end

  open_spacing #(.T_RRD(T_RRD), .BW(BANK_BITS)) i_spacing (
    .clk(clk), .rst_n(rst_n),
    .open_fire(is_open_c), .open_bank(cmd_bank),
    .rrd_met(rrd_met), .last_bank(last_bank)
  );

  always_comb begin
    evt = V_NONE;
    if (is_open_c && bank_open[cmd_bank]) evt = V_OPEN_BUSY;
    else if (is_open_c && !rc_met[cmd_bank]) evt = V_RC;
    else if (is_open_c && !rrd_met && cmd_bank != last_bank) evt = V_RRD;
    else if (is_rw_c && !bank_open[cmd_bank]) evt = V_RW_CLOSED;
    else if (is_rw_c && !rw_ok[cmd_bank]) evt = V_RCD;
    else if (|ras_over) evt = V_RAS;
  end

  fault_latch i_fault (
    .clk(clk), .rst_n(rst_n),
    .evt_code(evt),
    .flag(violation), .code(viol_code)
  );

  assign pd_enter = is_pd_c && !in_burst;
  assign pd_suspend = is_pd_c && in_burst;

  AST_PD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_enter && pd_suspend)); // R10
  AST_FIRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!violation && evt != V_NONE) |=> (violation && viol_code == $past(evt))); // R9
  AST_RAS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|ras_over) |=> violation); // R7
endmodule

// File: tb/test_sdram_act_guard.sv
module test_sdram_act_guard;
  localparam int T_RCD = 3;
  localparam int T_RC = 9;
  localparam int T_RRD = 2;
  localparam int T_RAS_MAX = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic in_burst = 1'b0;
  logic [3:0] act_ok, rw_ok, pre_ok;
  logic pd_enter, pd_suspend, violation;
  logic [2:0] viol_code;
  int tests = 0;
  int fails = 0;

  always #5ns clk = ~clk;

  sdram_act_guard #(
    .BANK_BITS(2), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RAS_MAX(T_RAS_MAX)
  ) i_sdram_act_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .in_burst(in_burst), .act_ok(act_ok), .rw_ok(rw_ok),
    .pre_ok(pre_ok), .pd_enter(pd_enter), .pd_suspend(pd_suspend),
    .violation(violation), .viol_code(viol_code)
  );

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; in_burst = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] bank, input logic vld = 1'b1);
    cmd_valid = vld; cmd_op = op; cmd_bank = bank;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 act_ok", int'(act_ok), 15);
    check("R1 rw_ok", int'(rw_ok), 0);
    check("R1 pre_ok", int'(pre_ok), 0);
    check("R1 viol", int'(violation), 0);
    check("R1 code", int'(viol_code), 0);

    // R1: invalid command ignored
    drive(3'd1, 2'd2, 1'b0);
    check("R1 ignored pre_ok", int'(pre_ok), 0);
    drive(3'd2, 2'd1, 1'b0);
    check("R1 ignored viol", int'(violation), 0);

    // R2 and R11: open-to-column sweep on every bank
    for (int b = 0; b < 4; b++) begin
      for (int g = 1; g <= T_RCD + 1; g++) begin
        do_reset();
        drive(3'd1, 2'(b));
        idle(g - 1);
        check("R2 rw_ok", int'(rw_ok[b]), (g >= T_RCD) ? 1 : 0);
        drive((g % 2) ? 3'd2 : 3'd3, 2'(b));
        check("R2 code", int'(viol_code), (g >= T_RCD) ? 0 : 5);
      end
    end

    // R4: same-bank open period sweep
    for (int g = 2; g <= T_RC + 1; g++) begin
      do_reset();
      drive(3'd1, 2'd1);
      drive(3'd4, 2'd1);
      idle(g - 2);
      check("R11 act_ok same bank", int'(act_ok[1]), (g >= T_RC) ? 1 : 0);
      drive(3'd1, 2'd1);
      check("R4 code", int'(viol_code), (g >= T_RC) ? 0 : 2);
    end

    // R5: cross-bank spacing sweep
    for (int g = 1; g <= T_RRD + 1; g++) begin
      do_reset();
      drive(3'd1, 2'd0);
      idle(g - 1);
      check("R5 act_ok other bank", int'(act_ok[1]), (g >= T_RRD) ? 1 : 0);
      drive(3'd1, 2'd1);
      check("R5 code", int'(viol_code), (g >= T_RRD) ? 0 : 3);
    end

    // R3: open on an open bank
    do_reset();
    drive(3'd1, 2'd2);
    idle(T_RC + 1);
    check("R11 act_ok open bank", int'(act_ok[2]), 0);
    drive(3'd1, 2'd2);
    check("R3 code", int'(viol_code), 1);

    // R6: read and write on a closed bank
    do_reset();
    drive(3'd2, 2'd3);
    check("R6 read code", int'(viol_code), 4);
    do_reset();
    drive(3'd3, 2'd0);
    check("R6 write code", int'(viol_code), 4);

    // R7: maximum open time, legal and late close
    for (int g = T_RAS_MAX; g <= T_RAS_MAX + 1; g++) begin
      do_reset();
      drive(3'd1, 2'd0);
      idle(g - 1);
      drive(3'd4, 2'd0);
      idle(2);
      check("R7 code", int'(viol_code), (g > T_RAS_MAX) ? 6 : 0);
    end

    // R9: sticky, first code kept
    do_reset();
    drive(3'd2, 2'd1);
    drive(3'd1, 2'd0);
    drive(3'd1, 2'd0);
    idle(5);
    check("R9 flag", int'(violation), 1);
    check("R9 first code", int'(viol_code), 4);

    // R8: single close and close-all
    do_reset();
    drive(3'd1, 2'd0);
    idle(T_RRD - 1);
    drive(3'd1, 2'd1);
    idle(T_RRD - 1);
    drive(3'd1, 2'd2);
    check("R8 pre_ok three open", int'(pre_ok), 7);
    drive(3'd4, 2'd1);
    check("R8 single close", int'(pre_ok), 5);
    drive(3'd5, 2'd3);
    check("R8 close all", int'(pre_ok), 0);
    check("R8 act_ok bank3", int'(act_ok[3]), 1);
    idle(T_RC);
    check("R8 act_ok all", int'(act_ok), 15);
    check("R8 no violation", int'(violation), 0);

    // R10: power-down classification
    do_reset();
    in_burst = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd6;
    #1ns;
    check("R10 suspend", int'(pd_suspend), 1);
    check("R10 no enter in burst", int'(pd_enter), 0);
    in_burst = 1'b0;
    #1ns;
    check("R10 enter", int'(pd_enter), 1);
    check("R10 no suspend", int'(pd_suspend), 0);
    cmd_valid = 1'b0;
    #1ns;
    check("R10 invalid", int'(pd_enter), 0);
    @(negedge clk);
    cmd_op = 3'd0;
    check("R10 no violation", int'(violation), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule